// File: doc/BRIEF.md
# Runahead Operand Validity Tracker with Speculative Store Cache

This block sits beside the retire stage of a core that keeps going past a long-latency load miss instead of stalling. While the core is in runahead mode, the results it produces are only for warming caches. Some of those results depend on data that has not arrived. The block takes one retiring instruction per cycle and keeps one invalid flag per architectural register. Invalid flags spread from a missing load to every instruction that depends on it, so bogus values are never used. The block reports, for each instruction, whether that instruction retires as invalid.

Stores seen in runahead mode never reach the real memory hierarchy. Each one is written into a small direct-mapped speculative store cache and retires at once. A later runahead load to the same word address takes its data from that cache. When the core leaves runahead mode, every flag and every cache entry is cleared in one cycle. Outside runahead mode the block is transparent: every instruction is reported valid and nothing is forwarded.

Top module: `ra_inv_tracker`

## Requirements
- R1: A synchronous active-high reset clears runahead mode, all register invalid flags, all store cache entries and all outputs. After reset, a runahead instruction that reads any register is reported valid, and a runahead load does not hit in the store cache.
- R2: Outside runahead mode, every instruction gives out_inv=0, out_fwd_hit=0 and out_fwd_data=0, and changes no state. A missing load outside the mode leaves its destination valid for later runahead use.
- R3: In runahead mode, a load with a valid address source that hits no store cache entry and has in_miss=1 is reported invalid and marks its destination invalid. With in_miss=0 it is valid and clears the destination flag.
- R4: In runahead mode, an ALU instruction with either source flagged invalid is reported invalid and marks its destination invalid. With both sources valid it is reported valid and clears its destination flag.
- R5: In runahead mode, a store with valid sources writes its tag and in_wdata into the entry at its index, marked usable, and is reported valid. A later runahead load with a valid address source and the same word address gives out_fwd_hit=1 and that data on out_fwd_data, is reported valid even if in_miss=1, and clears its destination flag.
- R6: In runahead mode, a store with an invalid address or data source is reported invalid and writes its entry marked invalid. A later load that hits that entry is reported invalid, marks its destination invalid and gives out_fwd_hit=0.
- R7: In runahead mode, a load whose address source is flagged invalid is reported invalid, marks its destination invalid and never forwards, whatever the cache holds.
- R8: The store cache is direct-mapped over word addresses. The index is in_addr[3:0] (16 entries) and the tag is the remaining upper bits. A load to the same index with a different tag does not hit, and a store to an occupied index replaces the entry.
- R9: Asserting ra_exit leaves runahead mode and clears all register flags and all cache entries by the next cycle. When ra_enter and ra_exit are asserted together, exit wins and the block ends up outside runahead mode.
- R10: Outputs are registered. The result of an instruction presented before clock edge k appears after edge k and holds for one cycle. out_valid follows in_valid with that latency. ra_enter takes effect for instructions after the edge that samples it.
- R11: The encoding of in_op is 2'b00 ALU (sources in_src_a and in_src_b, writes in_dst), 2'b01 load (address source in_src_a, writes in_dst), 2'b10 store (address source in_src_a, data source in_src_b, no destination) and 2'b11 no-op. A no-op is reported valid and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ra_enter | input | 1 | Pulse to enter runahead mode |
| ra_exit | input | 1 | Pulse to leave runahead mode and clear all state |
| in_valid | input | 1 | A retiring instruction is present |
| in_op | input | 2 | Instruction class: 00 ALU, 01 load, 10 store, 11 no-op |
| in_src_a | input | RIDX_W (5) | First source register; address source for loads and stores |
| in_src_b | input | RIDX_W (5) | Second source register; data source for stores |
| in_dst | input | RIDX_W (5) | Destination register |
| in_miss | input | 1 | Load missed in the real data cache |
| in_addr | input | ADDR_W (30) | Word address of a load or store |
| in_wdata | input | DATA_W (32) | Store data |
| out_valid | output | 1 | Registered copy of in_valid |
| out_inv | output | 1 | Instruction retired as invalid |
| out_fwd_hit | output | 1 | Load data forwarded from the store cache |
| out_fwd_data | output | DATA_W (32) | Forwarded load data, zero when there is no forward |

## Verification
The bench follows a chain of invalid flags from a missing load through ALU results, then checks that a later write with valid sources clears the flag. A design that never clears flags would report every later user invalid. It stores through an invalid source and loads the same word, so a design that forwards poisoned entries would show a hit with clean data. It also loads at an aliasing index with a different tag, which a design that compares only the index would wrongly forward. Finally it checks that leaving runahead mode, a simultaneous enter and exit, and a reset in the middle of runahead each leave no stale flag and no stale cache entry. A design that misses any of these would report an invalid or forwarded result after the state should be empty.

// File: rtl/ra_pkg.sv
`timescale 1ns/1ps
package ra_pkg;
  typedef enum logic [1:0] {
    OP_ALU   = 2'b00,
    OP_LOAD  = 2'b01,
    OP_STORE = 2'b10,
    OP_NOP   = 2'b11
  } op_e;
endpackage

// File: rtl/ra_inv_bits.sv
`timescale 1ns/1ps
// One invalid flag per architectural register, two read ports, one write port.
module ra_inv_bits #(
  parameter int NREG   = 32,
  parameter int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [RIDX_W-1:0] rd_a,
  input  logic [RIDX_W-1:0] rd_b,
  input  logic              we,
  input  logic [RIDX_W-1:0] wr_idx,
  input  logic              wr_inv,
  output logic              inv_a,
  output logic              inv_b
);
  logic [NREG-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst || clr) flags <= '0;
    else if (we)    flags[wr_idx] <= wr_inv;
  end

  assign inv_a = flags[rd_a];
  assign inv_b = flags[rd_b];

  AST_FLAGS_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (flags == '0)); // R9
endmodule

// File: rtl/ra_spec_cache.sv
`timescale 1ns/1ps
// Direct-mapped speculative store cache. Usable/poison flags sit in
// flops so they can be cleared in one cycle; tag and data sit in RAM.
module ra_spec_cache #(
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 30,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_inv,
  output logic              lk_hit,
  output logic              lk_inv,
  output logic [DATA_W-1:0] lk_data
);
  logic [ENTRIES-1:0] used;
  logic [ENTRIES-1:0] poison;
  logic [TAG_W-1:0]   tag_ram [ENTRIES];
  logic [DATA_W-1:0]  dat_ram [ENTRIES];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  assign idx = addr[IDX_W-1:0];
  assign tag = addr[ADDR_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      used   <= '0;
      poison <= '0;
    end else if (wr_en) begin
      used[idx]   <= 1'b1;
      poison[idx] <= wr_inv;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_ram[idx] <= tag;
      dat_ram[idx] <= wr_data;
    end
  end

  assign lk_hit  = used[idx] && (tag_ram[idx] == tag);
  assign lk_inv  = poison[idx];
  assign lk_data = dat_ram[idx];

  AST_CACHE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> (used == '0)); // R9
  AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && !clr) |-> used[$past(idx)]); // R5
endmodule

// File: rtl/ra_inv_tracker.sv
`timescale 1ns/1ps
module ra_inv_tracker #(
  parameter int NREG    = 32,
  parameter int ENTRIES = 16,
  parameter int ADDR_W  = 30,
  parameter int DATA_W  = 32,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ra_enter,
  input  logic              ra_exit,
  input  logic              in_valid,
  input  logic [1:0]        in_op,
  input  logic [RIDX_W-1:0] in_src_a,
  input  logic [RIDX_W-1:0] in_src_b,
  input  logic [RIDX_W-1:0] in_dst,
  input  logic              in_miss,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              out_valid,
  output logic              out_inv,
  output logic              out_fwd_hit,
  output logic [DATA_W-1:0] out_fwd_data
);
  import ra_pkg::*;

  logic ra_mode;
  op_e  op;
  logic active;
  logic inv_a, inv_b;
  logic c_hit, c_inv;
  logic [DATA_W-1:0] c_data;
  logic res_inv, fwd, dst_we, st_we;

  assign op     = op_e'(in_op);
  assign active = ra_mode && in_valid;

  always_ff @(posedge clk) begin
    if (rst || ra_exit) ra_mode <= 1'b0;
    else if (ra_enter)  ra_mode <= 1'b1;
  end

  ra_inv_bits #(.NREG(NREG)) u_bits (
    .clk(clk), .rst(rst), .clr(ra_exit),
    .rd_a(in_src_a), .rd_b(in_src_b),
    .we(dst_we), .wr_idx(in_dst), .wr_inv(res_inv),
    .inv_a(inv_a), .inv_b(inv_b)
  );

  ra_spec_cache #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cache (
    .clk(clk), .rst(rst), .clr(ra_exit),
    .addr(in_addr), .wr_en(st_we), .wr_data(in_wdata), .wr_inv(res_inv),
    .lk_hit(c_hit), .lk_inv(c_inv), .lk_data(c_data)
  );

  always_comb begin
    res_inv = 1'b0;
    fwd     = 1'b0;
    unique case (op)
      OP_ALU, OP_STORE: res_inv = inv_a | inv_b;
      OP_LOAD: begin
        if (inv_a)      res_inv = 1'b1;
        else if (c_hit) begin
          res_inv = c_inv;
          fwd     = !c_inv;
        end else        res_inv = in_miss;
      end
      default: res_inv = 1'b0;
    endcase
  end

  assign dst_we = active && !ra_exit && (op == OP_ALU || op == OP_LOAD);
  assign st_we  = active && !ra_exit && (op == OP_STORE);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_inv      <= 1'b0;
      out_fwd_hit  <= 1'b0;
      out_fwd_data <= '0;
    end else begin
      out_valid    <= in_valid;
      out_inv      <= active && res_inv;
      out_fwd_hit  <= active && fwd;
      out_fwd_data <= (active && fwd) ? c_data : '0;
    end
  end

  AST_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    !$past(ra_mode) |-> (!out_inv && !out_fwd_hit)); // R2
  AST_FWD_CLEAN: assert property (@(posedge clk) disable iff (rst)
    out_fwd_hit |-> !out_inv); // R5
  AST_FWD_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    out_fwd_hit |-> $past(in_valid && in_op == 2'b01)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_inv && !out_fwd_hit)); // R10
  AST_EXIT_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(ra_exit) |-> !ra_mode); // R9
endmodule

// File: tb/ra_inv_tracker_bench.sv
`timescale 1ns/1ps
module ra_inv_tracker_bench;
  localparam int ADDR_W = 30;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ra_enter = 0, ra_exit = 0, in_valid = 0, in_miss = 0;
  logic [1:0] in_op = 0;
  logic [4:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
  logic [ADDR_W-1:0] in_addr = 0;
  logic [DATA_W-1:0] in_wdata = 0;
  logic out_valid, out_inv, out_fwd_hit;
  logic [DATA_W-1:0] out_fwd_data;

  always #10 clk = ~clk;

  ra_inv_tracker u_ra_inv_tracker (
    .clk(clk), .rst(rst), .ra_enter(ra_enter), .ra_exit(ra_exit),
    .in_valid(in_valid), .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_dst(in_dst), .in_miss(in_miss), .in_addr(in_addr), .in_wdata(in_wdata),
    .out_valid(out_valid), .out_inv(out_inv), .out_fwd_hit(out_fwd_hit),
    .out_fwd_data(out_fwd_data)
  );

  typedef struct packed {
    logic v, en, ex;
    logic [1:0] op;
    logic [4:0] sa, sb, d;
    logic miss;
    logic [29:0] addr;
    logic [31:0] wd;
    logic ei, eh;
    logic [31:0] ed;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mkv(logic v, logic en, logic ex, logic [1:0] op,
      logic [4:0] sa, logic [4:0] sb, logic [4:0] d, logic miss,
      logic [29:0] addr, logic [31:0] wd, logic ei, logic eh,
      logic [31:0] ed, logic [3:0] rq);
    return '{v, en, ex, op, sa, sb, d, miss, addr, wd, ei, eh, ed, rq};
  endfunction

  // Addresses: 'h40 -> index 0 tag 4, 'h41 -> index 1, 'h140 -> index 0 tag 'h14
  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    mkv(0,1,0,2'b00, 0,0, 0,0,30'h0,  32'h0,        0,0,32'h0,        10), // R10 enter
    mkv(1,0,0,2'b01, 2,0, 1,1,30'h40, 32'h0,        1,0,32'h0,         3), // R3 miss
    mkv(1,0,0,2'b00, 1,4, 3,0,30'h0,  32'h0,        1,0,32'h0,         4), // R4 dep
    mkv(1,0,0,2'b00, 4,6, 5,0,30'h0,  32'h0,        0,0,32'h0,         4), // R4 clean
    mkv(1,0,0,2'b10, 4,5, 0,0,30'h41, 32'hDEADBEEF, 0,0,32'h0,         5), // R5 store
    mkv(1,0,0,2'b01, 4,0, 7,1,30'h41, 32'h0,        0,1,32'hDEADBEEF,  5), // R5 fwd
    mkv(1,0,0,2'b00, 7,5, 8,0,30'h0,  32'h0,        0,0,32'h0,         5), // R5 r7 valid
    mkv(1,0,0,2'b10, 4,3, 0,0,30'h40, 32'h11,       1,0,32'h0,         6), // R6 bad store
    mkv(1,0,0,2'b01, 4,0, 9,0,30'h40, 32'h0,        1,0,32'h0,         6), // R6 poisoned hit
    mkv(1,0,0,2'b00, 9,0,10,0,30'h0,  32'h0,        1,0,32'h0,         6), // R6 spread
    mkv(1,0,0,2'b01, 1,0,11,0,30'h41, 32'h0,        1,0,32'h0,         7), // R7
    mkv(1,0,0,2'b01, 4,0,12,0,30'h140,32'h0,        0,0,32'h0,         8), // R8 alias
    mkv(1,0,0,2'b10, 4,5, 0,0,30'h140,32'h12345678, 0,0,32'h0,         8), // R8 replace
    mkv(1,0,0,2'b01, 4,0,13,0,30'h140,32'h0,        0,1,32'h12345678,  8), // R8 hit
    mkv(1,0,0,2'b01, 4,0,14,1,30'h40, 32'h0,        1,0,32'h0,         8), // R8 evicted
    mkv(1,0,0,2'b00, 4,5, 3,0,30'h0,  32'h0,        0,0,32'h0,         4), // R4 clear r3
    mkv(1,0,0,2'b00, 3,4,15,0,30'h0,  32'h0,        0,0,32'h0,         4), // R4 r3 clean
    mkv(1,0,0,2'b11, 1,1, 1,0,30'h0,  32'h0,        0,0,32'h0,        11), // R11 nop
    mkv(1,0,0,2'b00, 1,1,16,0,30'h0,  32'h0,        1,0,32'h0,        11), // R11 r1 kept
    mkv(0,0,1,2'b00, 0,0, 0,0,30'h0,  32'h0,        0,0,32'h0,         9), // R9 exit
    mkv(1,0,0,2'b01, 4,0, 1,1,30'h41, 32'h0,        0,0,32'h0,         2), // R2 outside
    mkv(1,0,0,2'b00, 1,3,17,0,30'h0,  32'h0,        0,0,32'h0,         2), // R2 outside
    mkv(0,1,0,2'b00, 0,0, 0,0,30'h0,  32'h0,        0,0,32'h0,        10), // R10 enter
    mkv(1,0,0,2'b00, 1,14,18,0,30'h0, 32'h0,        0,0,32'h0,         9), // R9 flags gone
    mkv(1,0,0,2'b01, 4,0,19,0,30'h41, 32'h0,        0,0,32'h0,         9), // R9 cache gone
    mkv(1,0,0,2'b01, 4,0, 1,1,30'h40, 32'h0,        1,0,32'h0,         3), // R3 r1 bad
    mkv(0,1,1,2'b00, 0,0, 0,0,30'h0,  32'h0,        0,0,32'h0,         9), // R9 both
    mkv(1,0,0,2'b01, 4,0,21,1,30'h40, 32'h0,        0,0,32'h0,         9), // R9 exit won
    mkv(0,1,0,2'b00, 0,0, 0,0,30'h0,  32'h0,        0,0,32'h0,        10), // R10 enter
    mkv(1,0,0,2'b00, 1,1,20,0,30'h0,  32'h0,        0,0,32'h0,         9)  // R9 r1 cleared
  };

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(string tag, logic v, logic ei, logic eh, logic [31:0] ed);
    checks++;
    if (out_valid !== v || out_inv !== ei || out_fwd_hit !== eh || out_fwd_data !== ed) begin
      errors++;
      $display("FAIL %s: got valid=%b inv=%b hit=%b data=%h expected valid=%b inv=%b hit=%b data=%h",
               tag, out_valid, out_inv, out_fwd_hit, out_fwd_data, v, ei, eh, ed);
    end
  endtask

  task automatic run(vec_t x, string tag);
    @(negedge clk);
    in_valid = x.v; ra_enter = x.en; ra_exit = x.ex; in_op = x.op;
    in_src_a = x.sa; in_src_b = x.sb; in_dst = x.d; in_miss = x.miss;
    in_addr = x.addr; in_wdata = x.wd;
    @(negedge clk);
    in_valid = 0; ra_enter = 0; ra_exit = 0;
    check(tag, x.v, x.ei, x.eh, x.ed);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 0, 0, 0, 32'h0);
    rst = 0;
    for (int i = 0; i < NV; i++) run(VECS[i], $sformatf("R%0d vec%0d", VECS[i].rq, i));

    // Directed: reset in the middle of runahead (R1)
    run(mkv(0,1,0,2'b00,0,0,0,0,30'h0,0,0,0,0,1), "R1 enter");
    run(mkv(1,0,0,2'b01,4,0,1,1,30'h40,0,1,0,0,1), "R1 mark r1");
    run(mkv(1,0,0,2'b10,4,5,0,0,30'h41,32'hCAFE,0,0,0,1), "R1 store");
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk);
    check("R1 outputs in reset", 0, 0, 0, 32'h0);
    rst = 0;
    run(mkv(1,0,0,2'b00,1,1,2,0,30'h0,0,0,0,0,1), "R1 mode off after reset");
    run(mkv(0,1,0,2'b00,0,0,0,0,30'h0,0,0,0,0,1), "R1 enter");
    run(mkv(1,0,0,2'b00,1,1,2,0,30'h0,0,0,0,0,1), "R1 flags cleared");
    run(mkv(1,0,0,2'b01,4,0,3,0,30'h41,0,0,0,0,1), "R1 cache cleared");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule